// File: doc/BRIEF.md
# Prioritized Interrupt Level Evaluator

This block turns a set of pending interrupt requests into one priority level and decides whether that level interrupts the processor. Requests come from two places: a software request register, written by the processor, and a vector of external request lines. Each set bit of either source stands for a priority level. The block keeps the highest such level. When an evaluate strobe arrives and that level is strictly above the current priority level register, the block posts a one-cycle trap request. On the same edge it captures the combined request bitmap and the winning level.

The current priority level register and the software request register both live inside the block, and each has its own write strobe. A write keeps only the bits the register implements. A pending asynchronous-trap request is not supported. If one is present when an evaluation happens, the block raises a flag and posts no trap. Vectoring to the handler and masking of individual external sources are left to other logic.

Timing: a write lands on the clock edge where its strobe is sampled. An evaluation on that same edge still sees the old register contents. The trap pulse, the summary and the ID appear in the cycle after the evaluate strobe is sampled.

Top module: `irq_level_eval`

## Requirements
- R1: A software request write stores only bits 4 to 18 of the data (mask 0x7fff0). All other bits of the register read as zero.
- R2: A set software request bit i contributes level i - 3, so bit 4 gives level 1 and bit 18 gives level 15. It also sets bit i of the summary bitmap.
- R3: An external request bit i with 20 <= i <= 30 contributes level i and sets summary bit i. External bits outside that range have no effect on the level or on the summary.
- R4: The highest contributing level wins. Any in-range external request therefore overrides every software request.
- R5: A trap is posted only when the winning level is nonzero and strictly greater than the current priority level. A level equal to the current priority level posts nothing.
- R6: When a trap is posted, the summary output takes the combined bitmap and the ID output takes the winning level. Both appear in the cycle after the evaluate strobe, together with the trap pulse.
- R7: A write to the current priority level keeps bits 4:0 of the 8-bit data. For example, writing 0xFF gives 31.
- R8: An evaluation that sees any nonzero asynchronous-trap request raises the unsupported flag for one cycle. It posts no trap and leaves the summary and ID unchanged.
- R9: When no trap is posted, the summary and ID outputs keep their previous values.
- R10: The block evaluates only on a sampled evaluate strobe. The trap request is high only in the cycle after such a strobe.
- R11: After reset, all registers and outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evalStb | input | 1 | Evaluate the pending requests this cycle |
| swWr | input | 1 | Write strobe for the software request register |
| swWrData | input | 32 | Software request write data |
| iplWr | input | 1 | Write strobe for the current priority level |
| iplWrData | input | 8 | Priority level write data |
| extReq | input | 32 | External request lines, bit index = level |
| astReq | input | 4 | Pending asynchronous-trap requests |
| trapReq | output | 1 | One-cycle interrupt trap request |
| astUnsupported | output | 1 | One-cycle flag: evaluation met an asynchronous-trap request |
| summary | output | 32 | Request bitmap captured at the last trap |
| intId | output | 5 | Winning level captured at the last trap |
| swReq | output | 32 | Current software request register |
| curIpl | output | 5 | Current priority level register |

## Verification
Several properties are checked on every cycle: the masking of both register writes, the fact that a trap only follows an evaluate strobe, that the captured ID is nonzero and above the level that held at the strobe, that summary and ID stay still without a trap, and that an unsupported asynchronous-trap request never comes with a trap. Other behaviours can only be shown by the bench's scenarios, because they depend on which bit wins: the level remapping of software bits, external lines overriding software requests, out-of-range external lines being ignored, and the equal-level boundary. The bench's reference model is compared on every clock, and directed checks with hand-computed values cover these cases.

// File: rtl/irq_eval_pkg.sv
package irq_eval_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic loadSw;     // capture software request write
    logic loadIpl;    // capture priority level write
    logic latchTrap;  // capture summary and winning level
  } evalStrobe_t;
endpackage

// File: rtl/irq_eval_dp.sv
module irq_eval_dp
  import irq_eval_pkg::*;
#(
  parameter int REQ_W    = 32,
  parameter int SW_LO    = 4,
  parameter int SW_HI    = 18,
  parameter int EXT_LO   = 20,
  parameter int EXT_HI   = 30,
  parameter int IPL_IN_W = 8,
  parameter int LVL_W    = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  evalStrobe_t         strb,
  input  logic [REQ_W-1:0]    swWrData,
  input  logic [IPL_IN_W-1:0] iplWrData,
  input  logic [REQ_W-1:0]    extReq,
  output logic [REQ_W-1:0]    swReq,
  output logic [LVL_W-1:0]    curIpl,
  output logic [REQ_W-1:0]    summary,
  output logic [LVL_W-1:0]    intId,
  output logic [LVL_W-1:0]    candLevel
);
  logic [REQ_W-1:0] swMask;
  logic [REQ_W-1:0] extMask;
  logic [REQ_W-1:0] candMap;

  // Bit masks of implemented request positions
  for (genvar g = 0; g < REQ_W; g++) begin : gMask
    assign swMask[g]  = (g >= SW_LO)  && (g <= SW_HI);
    assign extMask[g] = (g >= EXT_LO) && (g <= EXT_HI);
  end

  assign candMap = swReq | (extReq & extMask);

  // Scan software levels first, then external; last hit wins
  always_comb begin
    candLevel = '0;
    for (int i = SW_LO; i <= SW_HI; i++) begin
      if (swReq[i]) candLevel = LVL_W'(i - SW_LO + 1);
    end
    for (int i = EXT_LO; i <= EXT_HI; i++) begin
      if (extReq[i]) candLevel = LVL_W'(i);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      swReq   <= '0;
      curIpl  <= '0;
      summary <= '0;
      intId   <= '0;
    end else begin
      if (strb.loadSw)    swReq   <= swWrData & swMask;
      if (strb.loadIpl)   curIpl  <= iplWrData[LVL_W-1:0];
      if (strb.latchTrap) begin
        summary <= candMap;
        intId   <= candLevel;
      end
    end
  end
endmodule

// File: rtl/irq_eval_ctrl.sv
module irq_eval_ctrl
  import irq_eval_pkg::*;
#(
  parameter int LVL_W = 5,
  parameter int AST_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             evalStb,
  input  logic             swWr,
  input  logic             iplWr,
  input  logic [AST_W-1:0] astReq,
  input  logic [LVL_W-1:0] candLevel,
  input  logic [LVL_W-1:0] curIpl,
  output evalStrobe_t      strb,
  output logic             trapReq,
  output logic             astUnsupported
);
  logic astSeen;
  logic levelWins;

  assign astSeen   = evalStb && (astReq != '0);
  assign levelWins = (candLevel != '0) && (candLevel > curIpl);

  always_comb begin
    strb.loadSw    = swWr;
    strb.loadIpl   = iplWr;
    strb.latchTrap = evalStb && !astSeen && levelWins;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trapReq        <= 1'b0;
      astUnsupported <= 1'b0;
    end else begin
      trapReq        <= strb.latchTrap;
      astUnsupported <= astSeen;
    end
  end
endmodule

// File: rtl/irq_level_eval.sv
module irq_level_eval
  import irq_eval_pkg::*;
#(
  parameter int REQ_W    = 32,
  parameter int SW_LO    = 4,
  parameter int SW_HI    = 18,
  parameter int EXT_LO   = 20,
  parameter int EXT_HI   = 30,
  parameter int IPL_IN_W = 8,
  parameter int AST_W    = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      evalStb,
  input  logic                      swWr,
  input  logic [REQ_W-1:0]          swWrData,
  input  logic                      iplWr,
  input  logic [IPL_IN_W-1:0]       iplWrData,
  input  logic [REQ_W-1:0]          extReq,
  input  logic [AST_W-1:0]          astReq,
  output logic                      trapReq,
  output logic                      astUnsupported,
  output logic [REQ_W-1:0]          summary,
  output logic [$clog2(REQ_W)-1:0]  intId,
  output logic [REQ_W-1:0]          swReq,
  output logic [$clog2(REQ_W)-1:0]  curIpl
);
  localparam int LVL_W = $clog2(REQ_W);

  evalStrobe_t      strb;
  logic [LVL_W-1:0] candLevel;

  irq_eval_ctrl #(.LVL_W(LVL_W), .AST_W(AST_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .evalStb(evalStb), .swWr(swWr), .iplWr(iplWr),
    .astReq(astReq), .candLevel(candLevel), .curIpl(curIpl),
    .strb(strb), .trapReq(trapReq), .astUnsupported(astUnsupported)
  );

  irq_eval_dp #(
    .REQ_W(REQ_W), .SW_LO(SW_LO), .SW_HI(SW_HI), .EXT_LO(EXT_LO),
    .EXT_HI(EXT_HI), .IPL_IN_W(IPL_IN_W), .LVL_W(LVL_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .swWrData(swWrData),
    .iplWrData(iplWrData), .extReq(extReq), .swReq(swReq), .curIpl(curIpl),
    .summary(summary), .intId(intId), .candLevel(candLevel)
  );
endmodule

// File: rtl/irq_level_eval_chk.sv
module irq_level_eval_chk #(
  parameter int REQ_W    = 32,
  parameter int SW_LO    = 4,
  parameter int SW_HI    = 18,
  parameter int IPL_IN_W = 8,
  parameter int AST_W    = 4,
  parameter int LVL_W    = 5
) (
  input logic                clk,
  input logic                rstN,
  input logic                evalStb,
  input logic                swWr,
  input logic [REQ_W-1:0]    swWrData,
  input logic                iplWr,
  input logic [IPL_IN_W-1:0] iplWrData,
  input logic [AST_W-1:0]    astReq,
  input logic                trapReq,
  input logic                astUnsupported,
  input logic [REQ_W-1:0]    summary,
  input logic [LVL_W-1:0]    intId,
  input logic [REQ_W-1:0]    swReq,
  input logic [LVL_W-1:0]    curIpl
);
  localparam logic [REQ_W-1:0] SW_KEEP =
    ((REQ_W'(1) << (SW_HI + 1)) - REQ_W'(1)) & ~((REQ_W'(1) << SW_LO) - REQ_W'(1));

  AST_SW_WRITE_MASK: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(swWr)) |-> (swReq == ($past(swWrData) & SW_KEEP))); // R1

  AST_IPL_WRITE_MASK: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(iplWr)) |-> (curIpl == $past(iplWrData[LVL_W-1:0]))); // R7

  AST_TRAP_ABOVE_IPL: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && trapReq) |-> ((intId != '0) && (intId > $past(curIpl)))); // R5

  AST_TRAP_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |-> ($past(rstN) && $past(evalStb))); // R10

  AST_HOLD_WITHOUT_TRAP: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !trapReq) |-> ($stable(summary) && $stable(intId))); // R9

  AST_AST_BLOCKS_TRAP: assert property (@(posedge clk) disable iff (!rstN)
    astUnsupported |-> (!trapReq && $past(rstN) && $past(astReq != '0))); // R8
endmodule

bind irq_level_eval irq_level_eval_chk #(
  .REQ_W(REQ_W), .SW_LO(SW_LO), .SW_HI(SW_HI), .IPL_IN_W(IPL_IN_W),
  .AST_W(AST_W), .LVL_W($clog2(REQ_W))
) chk_i (
  .clk(clk), .rstN(rstN), .evalStb(evalStb), .swWr(swWr), .swWrData(swWrData),
  .iplWr(iplWr), .iplWrData(iplWrData), .astReq(astReq), .trapReq(trapReq),
  .astUnsupported(astUnsupported), .summary(summary), .intId(intId),
  .swReq(swReq), .curIpl(curIpl)
);

// File: tb/irq_level_eval_tb_top.sv
`timescale 1ns/1ps
module irq_level_eval_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        evalStb = 1'b0;
  logic        swWr = 1'b0;
  logic [31:0] swWrData = '0;
  logic        iplWr = 1'b0;
  logic [7:0]  iplWrData = '0;
  logic [31:0] extReq = '0;
  logic [3:0]  astReq = '0;
  logic        trapReq, astUnsupported;
  logic [31:0] summary, swReq;
  logic [4:0]  intId, curIpl;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;  // 125 MHz

  irq_level_eval dut_i (
    .clk(clk), .rstN(rstN), .evalStb(evalStb), .swWr(swWr), .swWrData(swWrData),
    .iplWr(iplWr), .iplWrData(iplWrData), .extReq(extReq), .astReq(astReq),
    .trapReq(trapReq), .astUnsupported(astUnsupported), .summary(summary),
    .intId(intId), .swReq(swReq), .curIpl(curIpl)
  );

  // Behavioural reference model
  logic [31:0] mSw = '0, mSum = '0;
  int          mIpl = 0, mId = 0;
  bit          mTrap = 0, mAst = 0;

  always @(posedge clk or negedge rstN) begin
    int lvl;
    logic [31:0] map;
    if (!rstN) begin
      mSw = '0; mSum = '0; mIpl = 0; mId = 0; mTrap = 0; mAst = 0;
    end else begin
      mTrap = 0; mAst = 0;
      if (evalStb) begin
        lvl = 0; map = mSw;
        foreach (mSw[i]) if (i >= 4 && i <= 18 && mSw[i]) lvl = (lvl > i - 3) ? lvl : i - 3;
        foreach (extReq[i]) if (i >= 20 && i <= 30 && extReq[i]) begin
          lvl = (lvl > i) ? lvl : i;
          map[i] = 1'b1;
        end
        if (astReq != 0) mAst = 1;
        else if (lvl > 0 && lvl > mIpl) begin
          mTrap = 1; mSum = map; mId = lvl;
        end
      end
      if (swWr)  mSw  = swWrData & 32'h0007_fff0;
      if (iplWr) mIpl = int'(iplWrData) % 32;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    chk("R6 model trapReq", 32'(trapReq), 32'(mTrap));
    chk("R6 model summary", summary, mSum);
    chk("R6 model intId", 32'(intId), 32'(mId));
    chk("R1 model swReq", swReq, mSw);
    chk("R7 model curIpl", 32'(curIpl), 32'(mIpl));
    chk("R8 model astUnsupported", 32'(astUnsupported), 32'(mAst));
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wrSw(logic [31:0] d);
    swWr = 1'b1; swWrData = d; step(); swWr = 1'b0; swWrData = '0;
  endtask

  task automatic wrIpl(logic [7:0] d);
    iplWr = 1'b1; iplWrData = d; step(); iplWr = 1'b0; iplWrData = '0;
  endtask

  task automatic doEval(logic [31:0] ext, logic [3:0] ast);
    evalStb = 1'b1; extReq = ext; astReq = ast; step();
    evalStb = 1'b0; extReq = '0; astReq = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset trapReq", 32'(trapReq), 0);
    chk("R11 reset summary", summary, 0);
    chk("R11 reset swReq", swReq, 0);
    rstN = 1'b1;
    step();

    wrSw(32'hFFFF_FFFF);
    chk("R1 masked write", swReq, 32'h0007_fff0);

    wrSw(32'h0000_0010);
    doEval('0, '0);
    chk("R2 bit4 trap", 32'(trapReq), 1);
    chk("R2 bit4 level", 32'(intId), 1);
    chk("R6 bit4 summary", summary, 32'h0000_0010);
    step();
    chk("R10 single pulse", 32'(trapReq), 0);

    wrSw(32'h0004_0010);
    doEval('0, '0);
    chk("R2 bit18 level", 32'(intId), 15);
    chk("R4 highest sw wins summary", summary, 32'h0004_0010);

    wrSw(32'h0004_0000);
    doEval(32'h0010_0000, '0);
    chk("R4 external overrides", 32'(intId), 20);
    chk("R3 external summary", summary, 32'h0014_0000);

    wrIpl(8'hFF);
    chk("R7 level mask", 32'(curIpl), 31);
    wrIpl(8'h14);
    chk("R7 level write", 32'(curIpl), 20);

    wrSw(32'h0);
    doEval(32'h0010_0000, '0);
    chk("R5 equal level no trap", 32'(trapReq), 0);
    chk("R9 summary held", summary, 32'h0014_0000);
    chk("R9 id held", 32'(intId), 20);

    doEval(32'h0020_0000, '0);
    chk("R5 above level trap", 32'(trapReq), 1);
    chk("R5 above level id", 32'(intId), 21);

    wrIpl(8'h00);
    doEval(32'h8008_0001, '0);
    chk("R3 out of range ignored", 32'(trapReq), 0);
    chk("R3 summary untouched", summary, 32'h0020_0000);

    wrSw(32'h0000_0010);
    doEval('0, 4'h1);
    chk("R8 unsupported flag", 32'(astUnsupported), 1);
    chk("R8 no trap", 32'(trapReq), 0);
    chk("R8 id held", 32'(intId), 21);

    extReq = 32'h0200_0000; step(); extReq = '0;
    chk("R10 no strobe no trap", 32'(trapReq), 0);

    doEval(32'h0200_0000, '0);
    chk("R10 strobe traps", 32'(trapReq), 1);
    chk("R10 strobe level", 32'(intId), 25);
    step();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule